// File: doc/BRIEF.md
# Mixed-Page-Size Associative Translation Buffer

The block is a fully associative translation buffer. It has 64 entries. Each entry pairs a 64-bit tag word with a 64-bit translation word. A lookup compares a 64-bit key against every tag at once. It returns the translation word of the lowest-numbered valid entry that matches. Each entry masks its own comparison, using the page-size code held in its translation word. One search therefore serves a mix of page sizes. A diagnostic read returns one translation word, chosen by address bits. A write port loads one entry by index. The design is meant to be placed twice, once for instruction fetches and once for data accesses. Both copies behave the same way.

Responses are registered. A small response state machine holds what the output presents in the current cycle:
- `RSP_IDLE`: nothing is presented.
- `RSP_LOOKUP`: a lookup result with its hit or miss flag.
- `RSP_DIAG`: a diagnostic word.

Transitions are taken on every clock edge:
- `take_lookup`: any state goes to `RSP_LOOKUP` when a lookup is strobed.
- `take_diag`: any state goes to `RSP_DIAG` when only a diagnostic read is strobed.
- `go_idle`: any state goes to `RSP_IDLE` when nothing is strobed.
- `reset_idle`: a synchronous reset forces `RSP_IDLE`.

Top module: `xlat_cam`

## Requirements
- R1: A synchronous reset clears every translation word, so all entries are invalid, and the response output is idle (`rsp_valid` low) on the cycle after reset.
- R2: Bit 63 of a translation word marks its entry valid. An entry with bit 63 clear never matches a lookup, and a hit always returns a word with bit 63 set.
- R3: Size code 0 (translation bits 62:61 = 0) requires all 64 bits of tag and key to be equal.
- R4: Size code 1 leaves key/tag bits 15:12 out of the comparison. Every other bit must be equal.
- R5: Size code 2 leaves bits 18:12 out of the comparison. Every other bit must be equal.
- R6: Size code 3 leaves bits 21:12 out of the comparison. Bits 22 and above, and bits 11:0, must still be equal.
- R7: When several valid entries match, the lookup returns the translation word of the one with the lowest index, and `rsp_hit` is 1.
- R8: When no entry matches, the lookup returns zero data with `rsp_miss` = 1 and `rsp_hit` = 0. Hit and miss are never high together.
- R9: A diagnostic read takes its entry index from `dg_addr` bits 8:3 and ignores all other address bits. It returns that entry's translation word whether or not the entry is valid, with `rsp_hit` and `rsp_miss` both 0.
- R10: Every request strobe produces exactly one response, one clock later, marked by `rsp_valid`. A cycle with no strobe gives no response in the following cycle.
- R11: A write updates the tag and translation word at `wr_idx` on the clock edge. A lookup strobed in the same cycle sees the old contents, and a later lookup sees the new ones.
- R12: When a lookup and a diagnostic read are strobed in the same cycle, the response is the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup strobe |
| lk_key | input | 64 | Lookup search word |
| dg_req | input | 1 | Diagnostic read strobe |
| dg_addr | input | 64 | Diagnostic address; bits 8:3 select the entry |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word to store |
| wr_xlat | input | 64 | Translation word to store |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_data | output | 64 | Returned translation word (zero on miss) |
| rsp_hit | output | 1 | Lookup response with a match |
| rsp_miss | output | 1 | Lookup response without a match |

## Verification
Lookups are run against entries of all four size codes. For each code, one key changes only the masked bits, which tells a correctly sized mask from an exact compare. Further keys flip bit 11 and a bit just above the masked range, which tells a correct mask from one that is too wide. Overlapping entries at low and high indices separate first-match priority from last-match priority. Removing the low entry afterwards shows that the higher one takes over. Invalid entries are tried both through lookup, where they must miss, and through diagnostic reads that carry junk in the other address bits, where their stored word must come back. Same-cycle write-and-lookup and lookup-plus-diagnostic strobes show which contents and which request win.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int unsigned VALID_BIT = 63;
    localparam int unsigned SIZE_HI   = 62;
    localparam int unsigned SIZE_LO   = 61;
    localparam int unsigned PAGE_LSB  = 12;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_LOOKUP = 2'd1,
        RSP_DIAG   = 2'd2
    } rsp_state_e;

    // Compare mask for one entry: ones mark bits that take part in the match.
    function automatic logic [63:0] care_mask(input logic [1:0] size_code);
        logic [63:0] hole;
        unique case (size_code)
            2'd0:    hole = 64'd0;
            2'd1:    hole = 64'h0000_0000_0000_000F << PAGE_LSB;
            2'd2:    hole = 64'h0000_0000_0000_007F << PAGE_LSB;
            default: hole = 64'h0000_0000_0000_03FF << PAGE_LSB;
        endcase
        return ~hole;
    endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned W       = 64,
    localparam int unsigned IW     = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_idx,
    input  logic [W-1:0]                wr_tag,
    input  logic [W-1:0]                wr_xlat,
    output logic [ENTRIES-1:0][W-1:0]   tag_arr,
    output logic [ENTRIES-1:0][W-1:0]   xlat_arr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < int'(ENTRIES); e++) begin
                tag_arr[e]  <= '0;
                xlat_arr[e] <= '0;
            end
        end else if (wr_en) begin
            tag_arr[wr_idx]  <= wr_tag;
            xlat_arr[wr_idx] <= wr_xlat;
        end
    end
endmodule

// File: rtl/xlat_entry_match.sv
module xlat_entry_match
    import xlat_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] tag,
    input  logic [W-1:0] xlat,
    input  logic [W-1:0] key,
    output logic         hit
);
    logic [W-1:0] care;

    always_comb begin
        care = care_mask(xlat[SIZE_HI:SIZE_LO]);
        hit  = xlat[VALID_BIT] && (((tag ^ key) & care) == '0);
    end
endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
    parameter int unsigned N  = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned W       = 64,
    localparam int unsigned IW     = $clog2(ENTRIES),
    localparam int unsigned DG_LSB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_req,
    input  logic [W-1:0]  lk_key,
    input  logic          dg_req,
    input  logic [W-1:0]  dg_addr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_tag,
    input  logic [W-1:0]  wr_xlat,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic          rsp_hit,
    output logic          rsp_miss
);
    logic [ENTRIES-1:0][W-1:0] tag_arr;
    logic [ENTRIES-1:0][W-1:0] xlat_arr;
    logic [ENTRIES-1:0]        match_vec;
    logic                      lk_found;
    logic [IW-1:0]             lk_idx;
    logic [IW-1:0]             dg_idx;
    logic                      dg_addr_unused;

    rsp_state_e state_q, state_d;
    logic [W-1:0] data_q;
    logic         hit_q;

    xlat_store #(.ENTRIES(ENTRIES), .W(W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_xlat(wr_xlat),
        .tag_arr(tag_arr), .xlat_arr(xlat_arr)
    );

    genvar g;
    generate
        for (g = 0; g < int'(ENTRIES); g++) begin : g_ent
            xlat_entry_match #(.W(W)) u_match (
                .tag(tag_arr[g]), .xlat(xlat_arr[g]), .key(lk_key),
                .hit(match_vec[g])
            );
        end
    endgenerate

    xlat_first_hit #(.N(ENTRIES)) u_pick (
        .match(match_vec), .found(lk_found), .idx(lk_idx)
    );

    assign dg_idx         = dg_addr[DG_LSB +: IW];
    assign dg_addr_unused = ^{dg_addr[W-1:DG_LSB+IW], dg_addr[DG_LSB-1:0]};

    // Next-state selection: lookup outranks diagnostic read.
    always_comb begin
        if (lk_req)      state_d = RSP_LOOKUP;   // take_lookup
        else if (dg_req) state_d = RSP_DIAG;     // take_diag
        else             state_d = RSP_IDLE;     // go_idle
    end

    // State register with reset_idle.
    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_IDLE;
        else     state_q <= state_d;
    end

    // Result capture, taken from the contents before any same-edge write.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            hit_q  <= 1'b0;
        end else if (lk_req) begin
            data_q <= lk_found ? xlat_arr[lk_idx] : '0;
            hit_q  <= lk_found;
        end else if (dg_req) begin
            data_q <= xlat_arr[dg_idx];
            hit_q  <= 1'b0;
        end
    end

    // Output decode per state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        unique case (state_q)
            RSP_LOOKUP: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
                rsp_hit   = hit_q;
                rsp_miss  = !hit_q;
            end
            RSP_DIAG: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid);

    assert_hit_is_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_data[VALID_BIT]);

    assert_pick_matches_R7: assert property (@(posedge clk) disable iff (rst)
        lk_found |-> match_vec[lk_idx]);

    assert_pick_lowest_R7: assert property (@(posedge clk) disable iff (rst)
        lk_found |-> ((match_vec & ~({ENTRIES{1'b1}} << lk_idx)) == '0));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_miss));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_data == '0));

    assert_diag_no_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (dg_req && !lk_req) |=> (!rsp_hit && !rsp_miss && rsp_valid));

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        (lk_req || dg_req) |=> rsp_valid);

    assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        !(lk_req || dg_req) |=> !rsp_valid);

    assert_lookup_wins_R12: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (rsp_hit || rsp_miss));
endmodule

// File: tb/test_xlat_cam.sv
`timescale 1ns/1ps
module test_xlat_cam;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [63:0] lk_key = '0;
    logic        dg_req = 1'b0;
    logic [63:0] dg_addr = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0;
    logic [63:0] wr_xlat = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_hit;
    logic        rsp_miss;

    always #5 clk = ~clk;

    xlat_cam i_xlat_cam (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_key(lk_key),
        .dg_req(dg_req), .dg_addr(dg_addr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_xlat(wr_xlat), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] m_tag [64];
    logic [63:0] m_xl  [64];

    logic [63:0] q_data [$];
    logic        q_hit  [$];
    logic        q_miss [$];
    string       q_req  [$];

    function automatic bit model_match(int i, logic [63:0] key);
        int n;
        logic [63:0] ign;
        case (m_xl[i][62:61])
            2'd0: n = 0;
            2'd1: n = 4;
            2'd2: n = 7;
            default: n = 10;
        endcase
        ign = ((64'd1 << n) - 64'd1) << 12;
        return m_xl[i][63] && ((m_tag[i] & ~ign) == (key & ~ign));
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expectation per response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_data, 64'd0);
            end else begin
                logic [63:0] d;
                logic h, m;
                string r;
                d = q_data.pop_front();
                h = q_hit.pop_front();
                m = q_miss.pop_front();
                r = q_req.pop_front();
                check(rsp_data == d && rsp_hit == h && rsp_miss == m, r,
                      {rsp_data[63:2], rsp_hit, rsp_miss}, {d[63:2], h, m});
            end
        end
    end

    task automatic issue(bit do_lk, logic [63:0] key, bit do_dg, logic [63:0] addr,
                         bit do_wr, logic [5:0] widx, logic [63:0] wtag,
                         logic [63:0] wxl, string req);
        @(negedge clk);
        lk_req = do_lk; lk_key = key;
        dg_req = do_dg; dg_addr = addr;
        wr_en = do_wr; wr_idx = widx; wr_tag = wtag; wr_xlat = wxl;
        if (do_lk) begin
            logic [63:0] d;
            bit f;
            d = '0; f = 0;
            for (int i = 0; i < 64; i++) begin
                if (!f && model_match(i, key)) begin
                    f = 1; d = m_xl[i];
                end
            end
            q_data.push_back(d); q_hit.push_back(f); q_miss.push_back(!f);
            q_req.push_back(req);
        end else if (do_dg) begin
            q_data.push_back(m_xl[addr[8:3]]); q_hit.push_back(0); q_miss.push_back(0);
            q_req.push_back(req);
        end
        if (do_wr) begin
            m_tag[widx] = wtag;
            m_xl[widx]  = wxl;
        end
        @(negedge clk);
        lk_req = 0; dg_req = 0; wr_en = 0;
    endtask

    task automatic lookup(logic [63:0] key, string req);
        issue(1, key, 0, '0, 0, '0, '0, '0, req);
    endtask

    task automatic diag(int idx, string req);
        issue(0, '0, 1, 64'hDEAD_0000_0000_F005 | (64'(idx) << 3), 0, '0, '0, '0, req);
    endtask

    task automatic write(int idx, logic [63:0] tag, logic [63:0] xl);
        issue(0, '0, 0, '0, 1, 6'(idx), tag, xl, "write");
    endtask

    localparam logic [63:0] T0 = 64'h0000_1234_5678_9000;
    localparam logic [63:0] T1 = 64'h0000_0000_00AB_0000;
    localparam logic [63:0] T2 = 64'h0000_0000_1200_0000;
    localparam logic [63:0] T3 = 64'h0000_0003_0000_0000;
    localparam logic [63:0] TD = 64'h0000_0055_0000_0000;
    localparam logic [63:0] TP = 64'h0000_0777_0000_0000;

    initial begin
        for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_xl[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);
        lookup(64'd0, "R1 all invalid after reset");
        diag(5, "R1 cleared word");

        write(3, T0, 64'h8000_0000_0000_0A03);
        lookup(T0, "R3 exact hit");
        lookup(T0 ^ (64'd1 << 12), "R3 bit12 differs");
        lookup(T0 ^ (64'd1 << 63), "R8 top bit differs");

        write(10, T1, 64'hA000_0000_0000_0010);
        lookup(T1 | 64'hF000, "R4 masked bits");
        lookup(T1 ^ (64'd1 << 16), "R4 bit16 compared");
        lookup(T1 ^ (64'd1 << 11), "R4 bit11 compared");

        write(20, T2, 64'hC000_0000_0000_0020);
        lookup(T2 | 64'h7F000, "R5 masked bits");
        lookup(T2 ^ (64'd1 << 19), "R5 bit19 compared");

        write(30, T3, 64'hE000_0000_0000_0030);
        lookup(T3 | 64'h3FF000, "R6 masked bits");
        lookup(T3 ^ (64'd1 << 22), "R6 bit22 compared");
        lookup(T3 ^ (64'd1 << 11), "R6 bit11 compared");

        write(40, TD, 64'h6000_0000_0000_0040);
        lookup(TD, "R2 invalid never matches");
        diag(40, "R9 invalid entry read");
        diag(30, "R9 valid entry read");

        write(50, TP, 64'h8000_0000_0000_0050);
        write(60, TP, 64'h8000_0000_0000_0060);
        write(7, TP | 64'h5000, 64'hE000_0000_0000_0007);
        lookup(TP, "R7 lowest of three");
        write(7, TP, 64'h0000_0000_0000_0007);
        lookup(TP, "R7 next lowest after removal");

        issue(1, T0, 0, '0, 1, 6'd3, T0, 64'h8000_0000_0000_0B03, "R11 same cycle old");
        lookup(T0, "R11 new contents");

        issue(1, T1, 1, 64'd40 << 3, 0, '0, '0, '0, "R12 lookup wins");

        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 no response without strobe", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check(q_data.size() == 0, "R10 all responses seen", 64'(q_data.size()), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule